// File: doc/BRIEF.md
# Serial Flash Interrupt Status and Mask Controller

This block gathers the event indications of a serial flash controller into one 13-bit interrupt status register and drives a single active-high interrupt line. Each status bit has a companion enable bit in a mask register. A status bit latches only while its enable bit is set. Events that arrive while the bit is disabled are dropped and never latched. The interrupt line is a registered OR of all status bits.

Software reaches both registers over a simple register bus. A request is presented for one cycle, and read data is valid in that same cycle. Most status bits are cleared by writing 1 to them. The transmit underflow and receive overflow bits are cleared instead by a read of the status register. The five FIFO-related bits only latch while the legacy-mode input is high. Two of them compare a FIFO level with a threshold inside the block. When a set and a clear reach the same bit in the same cycle, the set takes priority, so no event is lost.

Top module: `flash_irq_ctrl`

## Requirements
- R1: A status bit becomes 1 on the clock edge where its event input is high only if its mask bit is 1. An event seen while the mask bit is 0 leaves the status bit at 0.
- R2: `irq_o` is a register that equals the OR of all status bits as they stood one cycle earlier. It resets to 1, because the reset status is nonzero.
- R3: Status bit positions are: 1 transmit underflow, 2 indirect operation done, 3 indirect request rejected, 4 protected write attempt, 5 illegal bus access, 6 indirect watermark, 7 receive overflow, 8 transmit threshold, 9 transmit full, 10 receive threshold, 11 receive full, 12 SRAM read partition full. Bit 0 and bits 31:13 always read 0.
- R4: A write to the status register clears each bit in 2 to 6 and 8 to 12 whose write data bit is 1. Write data bits that are 0 leave those bits unchanged.
- R5: Bits 1 and 7 are not affected by writes. A read of the status register returns their current value and clears them on that read's clock edge.
- R6: If a set of a bit coincides with its clear, either by write-1 or by read, the bit is 1 afterwards.
- R7: Events for bits 7 to 11 are ignored while `legacy_mode_i` is 0.
- R8: After reset the status register reads 0x00000100 and the mask register reads 0.
- R9: The receive threshold event is true when `rx_level_i` > `rx_thresh_i`. The transmit threshold event is true when `tx_level_i` <= `tx_thresh_i`.
- R10: The status register is at offset 0x40 and the mask register is at offset 0x44. Mask bits 12:1 are read/write, and all other mask bits read 0. Reads at any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access request, one cycle per access |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | Byte offset of the register |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, valid in the request cycle |
| legacy_mode_i | input | 1 | Legacy mode qualifier for bits 7 to 11 |
| ev_underflow_i | input | 1 | Transmit FIFO underflow pulse |
| ev_op_done_i | input | 1 | Indirect operation completed pulse |
| ev_reject_i | input | 1 | Indirect request rejected (queue of two full) pulse |
| ev_prot_wr_i | input | 1 | Protected-area write attempt pulse |
| ev_illegal_i | input | 1 | Illegal bus access (wrapping burst, split/retry) pulse |
| ev_wmark_i | input | 1 | Indirect watermark reached pulse |
| ev_rx_ovf_i | input | 1 | Push into full receive FIFO pulse |
| ev_sram_full_i | input | 1 | Indirect read SRAM partition full pulse |
| tx_full_i | input | 1 | Transmit FIFO full level |
| rx_full_i | input | 1 | Receive FIFO full level |
| tx_level_i | input | LVL_W | Transmit FIFO fill level |
| tx_thresh_i | input | LVL_W | Transmit FIFO threshold |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| rx_thresh_i | input | LVL_W | Receive FIFO threshold |
| irq_o | output | 1 | Interrupt, active high |

## Verification
The checker verifies on every cycle the following properties: masking, the one-cycle registered interrupt, the reserved bits staying zero, the immunity of bits 1 and 7 to writes, and the legacy gating. Some behaviour only the bench's scenarios can show. This covers the exact read values at each offset, the threshold boundaries where level equals threshold, and set-over-clear priority. It also covers a clear-on-read returning the value from before the clear and the reset value of the threshold bit.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;
  localparam int STAT_W = 13;

  localparam int B_UNDERFLOW = 1;
  localparam int B_OP_DONE   = 2;
  localparam int B_REJECT    = 3;
  localparam int B_PROT_WR   = 4;
  localparam int B_ILLEGAL   = 5;
  localparam int B_WMARK     = 6;
  localparam int B_RX_OVF    = 7;
  localparam int B_TX_THR    = 8;
  localparam int B_TX_FULL   = 9;
  localparam int B_RX_THR    = 10;
  localparam int B_RX_FULL   = 11;
  localparam int B_SRAM_FULL = 12;

  localparam logic [STAT_W-1:0] STAT_RST    = 13'h0100;
  localparam logic [STAT_W-1:0] IMPL_BITS   = 13'h1FFE;
  localparam logic [STAT_W-1:0] COR_BITS    = 13'h0082;
  localparam logic [STAT_W-1:0] LEGACY_BITS = 13'h0F80;

  typedef enum logic [1:0] {CLR_NONE, CLR_W1C, CLR_COR} clr_kind_e;

  function automatic clr_kind_e clr_kind(int b);
    if (!IMPL_BITS[b]) return CLR_NONE;
    if (COR_BITS[b])   return CLR_COR;
    return CLR_W1C;
  endfunction
endpackage

// File: rtl/flash_irq_evt.sv
module flash_irq_evt
  import flash_irq_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic              legacy_i,
  input  logic              underflow_i,
  input  logic              op_done_i,
  input  logic              reject_i,
  input  logic              prot_wr_i,
  input  logic              illegal_i,
  input  logic              wmark_i,
  input  logic              rx_ovf_i,
  input  logic              sram_full_i,
  input  logic              tx_full_i,
  input  logic              rx_full_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [LVL_W-1:0]  tx_thresh_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [LVL_W-1:0]  rx_thresh_i,
  output logic [STAT_W-1:0] evt_o
);
  logic [STAT_W-1:0] raw;
  logic [STAT_W-1:0] gate;

  always_comb begin
    raw              = '0;
    raw[B_UNDERFLOW] = underflow_i;
    raw[B_OP_DONE]   = op_done_i;
    raw[B_REJECT]    = reject_i;
    raw[B_PROT_WR]   = prot_wr_i;
    raw[B_ILLEGAL]   = illegal_i;
    raw[B_WMARK]     = wmark_i;
    raw[B_RX_OVF]    = rx_ovf_i;
    raw[B_TX_THR]    = (tx_level_i <= tx_thresh_i);
    raw[B_TX_FULL]   = tx_full_i;
    raw[B_RX_THR]    = (rx_level_i > rx_thresh_i);
    raw[B_RX_FULL]   = rx_full_i;
    raw[B_SRAM_FULL] = sram_full_i;
  end

  // FIFO-related bits pass only in legacy mode
  assign gate  = legacy_i ? IMPL_BITS : (IMPL_BITS & ~LEGACY_BITS);
  assign evt_o = raw & gate;
endmodule

// File: rtl/flash_irq_mask.sv
module flash_irq_mask
  import flash_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] mask_o
);
  logic [STAT_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (wr_i) mask_q <= wdata_i & IMPL_BITS;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/flash_irq_stat.sv
module flash_irq_stat
  import flash_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] evt_i,
  input  logic [STAT_W-1:0] mask_i,
  input  logic              wr_i,
  input  logic [STAT_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [STAT_W-1:0] stat_o
);
  logic unused_bits;
  assign unused_bits = ^((wdata_i | evt_i | mask_i) & ~IMPL_BITS);

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (clr_kind(b) == CLR_NONE) begin : g_rsvd
      assign stat_o[b] = 1'b0;
    end else begin : g_impl
      logic set_b, clr_b, q;
      assign set_b = evt_i[b] & mask_i[b];
      if (clr_kind(b) == CLR_COR) begin : g_cor
        assign clr_b = rd_i;
      end else begin : g_w1c
        assign clr_b = wr_i & wdata_i[b];
      end
      // set has priority over a same-cycle clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= STAT_RST[b];
        else         q <= set_b | (q & ~clr_b);
      end
      assign stat_o[b] = q;
    end
  end
endmodule

// File: rtl/flash_irq_ctrl.sv
module flash_irq_ctrl
  import flash_irq_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 32,
  parameter int                LVL_W    = 6,
  parameter logic [ADDR_W-1:0] STAT_OFF = 8'h40,
  parameter logic [ADDR_W-1:0] MASK_OFF = 8'h44
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              legacy_mode_i,
  input  logic              ev_underflow_i,
  input  logic              ev_op_done_i,
  input  logic              ev_reject_i,
  input  logic              ev_prot_wr_i,
  input  logic              ev_illegal_i,
  input  logic              ev_wmark_i,
  input  logic              ev_rx_ovf_i,
  input  logic              ev_sram_full_i,
  input  logic              tx_full_i,
  input  logic              rx_full_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [LVL_W-1:0]  tx_thresh_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [LVL_W-1:0]  rx_thresh_i,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - STAT_W;

  logic [STAT_W-1:0] evt, mask_q, stat_q, wdata;
  logic              hit_stat, hit_mask, wr_stat, wr_mask, rd_stat, irq_q;
  logic              unused_wdata;

  assign wdata        = reg_wdata_i[STAT_W-1:0];
  assign unused_wdata = ^reg_wdata_i[DATA_W-1:STAT_W];

  assign hit_stat = reg_req_i && (reg_addr_i == STAT_OFF);
  assign hit_mask = reg_req_i && (reg_addr_i == MASK_OFF);
  assign wr_stat  = hit_stat &&  reg_we_i;
  assign wr_mask  = hit_mask &&  reg_we_i;
  assign rd_stat  = hit_stat && !reg_we_i;

  flash_irq_evt #(.LVL_W(LVL_W)) u_evt (
    .legacy_i    (legacy_mode_i),
    .underflow_i (ev_underflow_i),
    .op_done_i   (ev_op_done_i),
    .reject_i    (ev_reject_i),
    .prot_wr_i   (ev_prot_wr_i),
    .illegal_i   (ev_illegal_i),
    .wmark_i     (ev_wmark_i),
    .rx_ovf_i    (ev_rx_ovf_i),
    .sram_full_i (ev_sram_full_i),
    .tx_full_i   (tx_full_i),
    .rx_full_i   (rx_full_i),
    .tx_level_i  (tx_level_i),
    .tx_thresh_i (tx_thresh_i),
    .rx_level_i  (rx_level_i),
    .rx_thresh_i (rx_thresh_i),
    .evt_o       (evt)
  );

  flash_irq_mask u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_mask),
    .wdata_i (wdata),
    .mask_o  (mask_q)
  );

  flash_irq_stat u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .mask_i  (mask_q),
    .wr_i    (wr_stat),
    .wdata_i (wdata),
    .rd_i    (rd_stat),
    .stat_o  (stat_q)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_req_i && !reg_we_i) begin
      if (hit_stat)      reg_rdata_o = {{PAD_W{1'b0}}, stat_q};
      else if (hit_mask) reg_rdata_o = {{PAD_W{1'b0}}, mask_q};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= |STAT_RST;
    else         irq_q <= |stat_q;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/flash_irq_ctrl_chk.sv
module flash_irq_ctrl_chk
  import flash_irq_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] STAT_OFF = 8'h40
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_req_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              legacy_mode_i,
  input logic [STAT_W-1:0] stat_q,
  input logic [STAT_W-1:0] mask_q,
  input logic              irq_o
);
  logic rd_stat;
  assign rd_stat = reg_req_i && !reg_we_i && (reg_addr_i == STAT_OFF);

  // R1
  mask_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(mask_q)) == '0));

  // R2
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|stat_q)));

  // R3
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q & ~IMPL_BITS) == '0);

  // R10
  mask_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q & ~IMPL_BITS) == '0);

  // R5
  cor_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_stat) |=> ((($past(stat_q) & ~stat_q) & COR_BITS) == '0));

  // R7
  legacy_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!legacy_mode_i) |=> ((stat_q & ~$past(stat_q) & LEGACY_BITS) == '0));
endmodule

bind flash_irq_ctrl flash_irq_ctrl_chk #(.ADDR_W(ADDR_W), .STAT_OFF(STAT_OFF)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_req_i     (reg_req_i),
  .reg_we_i      (reg_we_i),
  .reg_addr_i    (reg_addr_i),
  .legacy_mode_i (legacy_mode_i),
  .stat_q        (stat_q),
  .mask_q        (mask_q),
  .irq_o         (irq_o)
);

// File: tb/flash_irq_ctrl_test.sv
`timescale 1ns/1ps
module flash_irq_ctrl_test;
  localparam int LVL_W = 6;
  localparam logic [7:0] A_STAT = 8'h40;
  localparam logic [7:0] A_MASK = 8'h44;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic legacy = 1'b0;
  logic [12:0] ev = '0;
  logic tx_full = 1'b0, rx_full = 1'b0;
  logic [LVL_W-1:0] tx_lvl = 6'd5, tx_thr = 6'd2, rx_lvl = 6'd0, rx_thr = 6'd4;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk_i = ~clk_i;

  flash_irq_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .legacy_mode_i(legacy),
    .ev_underflow_i(ev[1]), .ev_op_done_i(ev[2]), .ev_reject_i(ev[3]),
    .ev_prot_wr_i(ev[4]), .ev_illegal_i(ev[5]), .ev_wmark_i(ev[6]),
    .ev_rx_ovf_i(ev[7]), .ev_sram_full_i(ev[12]),
    .tx_full_i(tx_full), .rx_full_i(rx_full),
    .tx_level_i(tx_lvl), .tx_thresh_i(tx_thr),
    .rx_level_i(rx_lvl), .rx_thresh_i(rx_thr),
    .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: compare read data against scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && req && !we) begin
      if (exp_q.size() == 0) check("unexpected read", rdata, 32'hx);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic bus(logic w, logic [7:0] a, logic [31:0] d);
    req = 1'b1; we = w; addr = a; wdata = d;
    tick();
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus(1'b0, a, '0);
  endtask

  task automatic pulse(logic [12:0] v);
    ev = v; tick(); ev = '0;
  endtask

  task automatic irq_chk(logic exp, string tag);
    @(negedge clk_i);
    check(tag, {31'd0, irq}, {31'd0, exp});
    tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    // R8 reset values; R2 irq reset high since bit 8 resets set
    rd(A_STAT, 32'h100, "R8 status reset");
    rd(A_MASK, 32'h0, "R8 mask reset");
    irq_chk(1'b1, "R2 irq after reset");
    // R4 write 0 keeps, write 1 clears bit 8
    bus(1'b1, A_STAT, 32'h0);
    rd(A_STAT, 32'h100, "R4 write zero keeps");
    bus(1'b1, A_STAT, 32'h100);
    rd(A_STAT, 32'h0, "R4 w1c bit8");
    tick();
    irq_chk(1'b0, "R2 irq low after clear");
    // R1 masked event dropped
    pulse(13'h0004);
    rd(A_STAT, 32'h0, "R1 masked event dropped");
    // R10 mask RW bits 12:1 only, unknown offset reads 0
    bus(1'b1, A_MASK, 32'hFFFF_FFFF);
    rd(A_MASK, 32'h1FFE, "R10 mask implemented bits");
    rd(8'h48, 32'h0, "R10 unmapped offset");
    // R1/R3 op done at bit 2; R2 one-cycle delay
    pulse(13'h0004);
    @(negedge clk_i);
    check("R2 irq not yet", {31'd0, irq}, 32'd0);
    tick();
    irq_chk(1'b1, "R2 irq one cycle later");
    rd(A_STAT, 32'h004, "R3 op done bit2");
    bus(1'b1, A_STAT, 32'h004);
    rd(A_STAT, 32'h0, "R4 w1c bit2");
    // R7 legacy off: overflow, full flags, thresholds ignored
    tx_lvl = 6'd1; rx_lvl = 6'd9; tx_full = 1'b1; rx_full = 1'b1;
    pulse(13'h0080);
    rd(A_STAT, 32'h0, "R7 legacy bits ignored");
    tx_lvl = 6'd5; rx_lvl = 6'd0; tx_full = 1'b0; rx_full = 1'b0;
    legacy = 1'b1;
    // R5 overflow not cleared by write, cleared by read
    pulse(13'h0080);
    bus(1'b1, A_STAT, 32'h080);
    rd(A_STAT, 32'h080, "R5 write no effect bit7");
    rd(A_STAT, 32'h0, "R5 cleared by read bit7");
    // R6 read coincident with push keeps bit7
    pulse(13'h0080);
    ev = 13'h0080;
    rd(A_STAT, 32'h080, "R6 read during push");
    ev = '0;
    rd(A_STAT, 32'h080, "R6 bit7 survives read");
    rd(A_STAT, 32'h0, "R5 bit7 cleared");
    // R6 w1c coincident with set keeps bit4
    pulse(13'h0010);
    ev = 13'h0010;
    bus(1'b1, A_STAT, 32'h010);
    ev = '0;
    rd(A_STAT, 32'h010, "R6 set beats w1c bit4");
    bus(1'b1, A_STAT, 32'h010);
    rd(A_STAT, 32'h0, "R4 w1c bit4");
    // R9 receive threshold boundary
    rx_lvl = 6'd4; tick();
    rd(A_STAT, 32'h0, "R9 rx level equal not above");
    rx_lvl = 6'd5; tick(); rx_lvl = 6'd0;
    rd(A_STAT, 32'h400, "R9 rx level above");
    bus(1'b1, A_STAT, 32'h400);
    // R9 transmit threshold boundary
    tx_lvl = 6'd3; tick();
    rd(A_STAT, 32'h0, "R9 tx level above not set");
    tx_lvl = 6'd2; tick(); tx_lvl = 6'd5;
    rd(A_STAT, 32'h100, "R9 tx level equal sets");
    bus(1'b1, A_STAT, 32'h100);
    // R3 remaining bits
    tx_full = 1'b1; rx_full = 1'b1;
    pulse(13'h1000 | 13'h0020 | 13'h0008 | 13'h0040 | 13'h0002);
    tx_full = 1'b0; rx_full = 1'b0;
    rd(A_STAT, 32'h1A6A, "R3 all remaining bits");
    bus(1'b1, A_STAT, 32'h1FFF);
    rd(A_STAT, 32'h0, "R5 underflow cleared by read");
    // R1 partial mask
    bus(1'b1, A_MASK, 32'h0008);
    pulse(13'h0018);
    rd(A_STAT, 32'h008, "R1 partial mask");
    if (exp_q.size() != 0) check("R10 scoreboard drained", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule